// File: doc/BRIEF.md
# Multiplexed-Bus Host Register Port

This block is the host-facing register port of a line-framer chip. A small microcontroller reaches it over one 8-bit bus that carries first an address and then data. A latch-enable strobe marks the address phase. Read and write phases follow one of two strobe conventions, chosen by a strap pin. In split-strobe mode there are separate active-low read and write strobes. In enable-clock mode the read pin carries an active-high enable clock and the write pin carries a read/not-write level. All host pins are brought into the system clock through a two-flop synchronizer before any edge is detected.

Behind the port sits a small register file. It holds four saturating 8-bit error counters, which the framer's event pulses drive. It also holds an interrupt status register and an interrupt mask register, and it drives two active-low interrupt lines: one for data-link events and one for counter and maintenance events. A second strap turns the whole host interface off. An active-low initialize input zeroes the counters and locks the host out while it is low. The block works from its system reset alone and does not need an initialize pulse.

Top module: `host_regport`

## Requirements
- R1: The register address is the bus value present while `ale` is high, captured when `ale` falls; the following read or write strobe accesses that address.
- R2: With `strobe_sel`=0 (split-strobe), `cs`=1 and `rd_n` low form a read; `cs`=1 and `wr_n` low form a write, and the data is taken when the write strobe is released.
- R3: With `strobe_sel`=1 (enable-clock), `rd_n` carries the enable clock (high = active) and `wr_n` carries read/not-write (1 = read, 0 = write). A write takes effect when the enable clock falls.
- R4: With `cs`=0, strobes have no effect: no register changes and `ad_oe` stays low.
- R5: With `host_off`=1, every host access is ignored and `ad_oe` stays low.
- R6: `ad_oe` is high only while chip select and the read qualifier are both true (host enabled, initialize inactive). During a read, `ad_out` carries the addressed register. During a write, `ad_oe` stays low.
- R7: Register map: addresses 0 to 3 are the error counters (read-only; writes are ignored), 4 is interrupt status, 5 is interrupt mask (read/write), and every other address reads 0 and ignores writes.
- R8: A high `cnt_evt[i]` in a clock cycle increments counter i. Each counter saturates at 255 and does not wrap.
- R9: Status bits [1:0] are set by `dl_evt[1:0]`. Bits [5:2] are set when counter 0 to 3 reaches 255. Bits [7:6] are set by `mt_evt[1:0]`. Writing 1 to a status bit clears it, writing 0 leaves it alone, and a new event wins over a clear in the same cycle.
- R10: A mask bit of 1 masks the matching status bit. `irq_dl_n` is low while any unmasked bit of status[1:0] is set. `irq_cm_n` is low while any unmasked bit of status[7:2] is set.
- R11: While `init_n` is low, all counters are held at zero, host reads and writes are ignored and `ad_oe` stays low. Status and mask keep their values.
- R12: A low `rst_n` at a clock edge zeroes every register (mask included). Afterwards both interrupt lines are high and `ad_oe` is low, with no initialize pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_n | input | 1 | Active-low initialize: clears counters, locks out the host |
| host_off | input | 1 | Strap: 1 disables the host interface |
| strobe_sel | input | 1 | Strap: 0 split-strobe, 1 enable-clock convention |
| ale | input | 1 | Address latch enable |
| rd_n | input | 1 | Read strobe (split) or enable clock (enable-clock mode) |
| wr_n | input | 1 | Write strobe (split) or read/not-write (enable-clock mode) |
| cs | input | 1 | Active-high chip select |
| ad_in | input | 8 | Bus value driven by the host |
| ad_out | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Bus output enable |
| cnt_evt | input | 4 | Error event pulses, one per counter |
| dl_evt | input | 2 | Data-link event pulses |
| mt_evt | input | 2 | Maintenance event pulses |
| irq_dl_n | output | 1 | Active-low data-link interrupt |
| irq_cm_n | output | 1 | Active-low counter/maintenance interrupt |

## Verification
The hardest state to reach from the ports is counter saturation. Only a counter that has passed from 254 to 255 sets its status bit and raises the counter interrupt. The stimulus therefore holds one event input high for 260 cycles, then reads the counter and the status register through a full bus transaction. It also checks that further events neither wrap the counter nor set the bit again once it has been cleared. A second awkward case is an initialize that overlaps a complete host write: the bench holds `init_n` low across the whole transaction and reads the mask back after release to show the write was lost.

// File: rtl/hbr_pkg.sv
// Package: shared widths and register addresses for the host register port.
// Assumes a status register no wider than the data bus.
package hbr_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_CNT     = 4;
    localparam int NUM_DL      = 2;
    localparam int NUM_MT      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int ST_W        = NUM_DL + NUM_CNT + NUM_MT;
    localparam int ADDR_STATUS = NUM_CNT;
    localparam int ADDR_MASK   = NUM_CNT + 1;
    localparam int CTRL_W      = 5;
    localparam int PIN_W       = CTRL_W + DATA_W;
endpackage

// File: rtl/hbr_sync.sv
// Module: multi-stage synchronizer for the asynchronous host pins.
// Assumes each bit is used only when its neighbours are stable, as the
// bus protocol guarantees for data around strobe edges.
module hbr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbr_strobe.sv
// Module: strobe decoder. Turns the synchronized pins into an address
// latch, a read-active level and a one-cycle write event with its data.
// Assumes the bus is stable for at least one cycle around each strobe edge.
module hbr_strobe #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_sel,
    input  logic          host_en,
    input  logic          ale_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic          cs_s,
    input  logic [DW-1:0] ad_s,
    output logic [DW-1:0] addr_q,
    output logic          rd_act,
    output logic          wr_evt,
    output logic [DW-1:0] wr_data
);
    logic          ale_d;
    logic          wq_d;
    logic [DW-1:0] ad_d;
    logic          rq;
    logic          wq;

    // Read and write qualifiers for the chosen strobe convention.
    always_comb begin
        if (strobe_sel) begin
            rq = host_en && cs_s && rd_s && wr_s;
            wq = host_en && cs_s && rd_s && !wr_s;
        end else begin
            rq = host_en && cs_s && !rd_s;
            wq = host_en && cs_s && !wr_s;
        end
    end

    // Edge history and address capture on the falling latch enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_d  <= 1'b0;
            wq_d   <= 1'b0;
            ad_d   <= '0;
            addr_q <= '0;
        end else begin
            ale_d <= ale_s;
            wq_d  <= wq;
            ad_d  <= ad_s;
            if (host_en && ale_d && !ale_s) addr_q <= ad_d;
        end
    end

    assign rd_act  = rq;
    assign wr_evt  = host_en && wq_d && !wq;
    assign wr_data = ad_d;

    // R5: a disabled host interface neither reads nor writes.
    a_r5_no_access_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !host_en |-> (!rd_act && !wr_evt));
endmodule

// File: rtl/hbr_regfile.sv
// Module: error counters, interrupt status and mask, read mux and
// interrupt outputs. Assumes single-cycle event pulses in the clk domain.
module hbr_regfile
    import hbr_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NCNT = NUM_CNT,
    parameter int NDL  = NUM_DL,
    parameter int NMT  = NUM_MT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [DW-1:0]   addr,
    input  logic            wr_evt,
    input  logic [DW-1:0]   wr_data,
    input  logic [NCNT-1:0] cnt_evt,
    input  logic [NDL-1:0]  dl_evt,
    input  logic [NMT-1:0]  mt_evt,
    output logic [DW-1:0]   rdata,
    output logic            irq_dl_n,
    output logic            irq_cm_n
);
    localparam int SW = NDL + NCNT + NMT;
    localparam logic [DW-1:0] CMAX = '1;
    localparam logic [SW-1:0] DL_GRP = SW'((1 << NDL) - 1);
    localparam logic [DW-1:0] A_ST = DW'(NCNT);
    localparam logic [DW-1:0] A_MK = DW'(NCNT + 1);

    logic [NCNT-1:0][DW-1:0] cnt_q;
    logic [NCNT-1:0]         sat_set;
    logic [SW-1:0]           status_q;
    logic [DW-1:0]           mask_q;
    logic [SW-1:0]           set_vec;
    logic [SW-1:0]           clr_vec;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        // Saturating error counter i, zeroed while initialize is active.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cnt_q[i] <= '0;
            else if (clr)                         cnt_q[i] <= '0;
            else if (cnt_evt[i] && cnt_q[i] != CMAX) cnt_q[i] <= cnt_q[i] + 1'b1;
        end

        assign sat_set[i] = !clr && cnt_evt[i] && (cnt_q[i] == CMAX - 1'b1);

        // R8: a full counter stays full.
        a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] == CMAX && !clr) |=> cnt_q[i] == CMAX);
        // R11: initialize leaves the counter at zero.
        a_r11_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> cnt_q[i] == '0);
    end

    assign set_vec = {mt_evt, sat_set, dl_evt};
    assign clr_vec = (wr_evt && addr == A_ST) ? wr_data[SW-1:0] : '0;

    // Status: events set bits, host writes of one clear them, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    for (genvar b = 0; b < SW; b++) begin : g_st_chk
        // R9: an event is never lost to a simultaneous clear.
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[b] |=> status_q[b]);
    end

    // Mask register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                      mask_q <= '0;
        else if (wr_evt && addr == A_MK) mask_q <= wr_data;
    end

    // Read mux over the register map.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (addr == DW'(i)) rdata = cnt_q[i];
        end
        if (addr == A_ST) rdata = DW'(status_q);
        if (addr == A_MK) rdata = mask_q;
    end

    // Interrupt lines per group.
    assign irq_dl_n = ~|(status_q & ~mask_q[SW-1:0] & DL_GRP);
    assign irq_cm_n = ~|(status_q & ~mask_q[SW-1:0] & ~DL_GRP);
endmodule

// File: rtl/host_regport.sv
// Module: host register port top. Synchronizes the host pins, decodes the
// strobes and serves the register file over a multiplexed bus.
// Assumes the host holds each bus phase for several system clock cycles.
module host_regport
    import hbr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_n,
    input  logic                host_off,
    input  logic                strobe_sel,
    input  logic                ale,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic                cs,
    input  logic [DATA_W-1:0]   ad_in,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    input  logic [NUM_CNT-1:0]  cnt_evt,
    input  logic [NUM_DL-1:0]   dl_evt,
    input  logic [NUM_MT-1:0]   mt_evt,
    output logic                irq_dl_n,
    output logic                irq_cm_n
);
    localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, {DATA_W{1'b0}}};

    logic [PIN_W-1:0]  pins_s;
    logic              init_s, cs_s, wr_s, rd_s, ale_s;
    logic [DATA_W-1:0] ad_s;
    logic              host_en;
    logic [DATA_W-1:0] addr_q;
    logic              rd_act;
    logic              wr_evt;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rdata;

    hbr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({init_n, cs, wr_n, rd_n, ale, ad_in}),
        .q     (pins_s)
    );

    assign {init_s, cs_s, wr_s, rd_s, ale_s, ad_s} = pins_s;
    assign host_en = !host_off && init_s;

    hbr_strobe #(.DW(DATA_W)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_sel (strobe_sel),
        .host_en    (host_en),
        .ale_s      (ale_s),
        .rd_s       (rd_s),
        .wr_s       (wr_s),
        .cs_s       (cs_s),
        .ad_s       (ad_s),
        .addr_q     (addr_q),
        .rd_act     (rd_act),
        .wr_evt     (wr_evt),
        .wr_data    (wr_data)
    );

    hbr_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!init_s),
        .addr     (addr_q),
        .wr_evt   (wr_evt),
        .wr_data  (wr_data),
        .cnt_evt  (cnt_evt),
        .dl_evt   (dl_evt),
        .mt_evt   (mt_evt),
        .rdata    (rdata),
        .irq_dl_n (irq_dl_n),
        .irq_cm_n (irq_cm_n)
    );

    assign ad_oe  = rd_act;
    assign ad_out = rdata;

    // R6: the bus is driven only under select with the host enabled.
    a_r6_oe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (cs_s && init_s && !host_off));
    // R6: no read drive while a write event fires.
    a_r6_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> !ad_oe);
endmodule

// File: tb/host_regport_test.sv
module host_regport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_n = 1'b1;
    logic       host_off = 1'b0;
    logic       strobe_sel = 1'b0;
    logic       ale = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       cs = 1'b0;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [3:0] cnt_evt = 4'h0;
    logic [1:0] dl_evt = 2'b00;
    logic [1:0] mt_evt = 2'b00;
    logic       irq_dl_n;
    logic       irq_cm_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    host_regport uut (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .host_off(host_off),
        .strobe_sel(strobe_sel), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .cs(cs),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .cnt_evt(cnt_evt),
        .dl_evt(dl_evt), .mt_evt(mt_evt), .irq_dl_n(irq_dl_n), .irq_cm_n(irq_cm_n)
    );

    // Vector: {enable-clock mode, write, address, data, expected read}
    localparam int NV = 11;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h05, 8'hA5, 8'h00},
        {1'b0, 1'b0, 8'h05, 8'h00, 8'hA5},
        {1'b1, 1'b1, 8'h05, 8'h3C, 8'h00},
        {1'b1, 1'b0, 8'h05, 8'h00, 8'h3C},
        {1'b0, 1'b0, 8'h07, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'hFF, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b1, 8'h06, 8'h55, 8'h00},
        {1'b0, 1'b0, 8'h06, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h05, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'h05, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic ec);
        @(negedge clk);
        strobe_sel = ec;
        ale = 1'b0;
        cs = 1'b0;
        rd_n = ec ? 1'b0 : 1'b1;
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One bus transaction; rv and oe are sampled mid-strobe.
    task automatic access(input logic wr, input logic csv, input logic [7:0] a,
                          input logic [7:0] d, output logic [7:0] rv, output logic oe);
        @(negedge clk);
        ale = 1'b1; ad_in = a; cs = csv;
        repeat (4) @(negedge clk);
        ale = 1'b0;
        repeat (4) @(negedge clk);
        ad_in = wr ? d : 8'h00;
        if (strobe_sel) begin
            wr_n = !wr;
            @(negedge clk);
            rd_n = 1'b1;
        end else if (wr) wr_n = 1'b0;
        else rd_n = 1'b0;
        repeat (6) @(negedge clk);
        rv = ad_out; oe = ad_oe;
        if (strobe_sel) begin
            rd_n = 1'b0;
            repeat (4) @(negedge clk);
            wr_n = 1'b1;
        end else begin
            rd_n = 1'b1; wr_n = 1'b1;
            repeat (4) @(negedge clk);
        end
        cs = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
        logic [7:0] v; logic o;
        access(1'b0, 1'b1, a, 8'h00, v, o);
        check(req, {7'd0, o}, 8'h01);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] v; logic o;
        access(1'b1, 1'b1, a, d, v, o);
        check("R6 no drive on write", {7'd0, o}, 8'h00);
    endtask

    task automatic pulse_cnt(input int idx, input int n);
        @(negedge clk);
        cnt_evt[idx] = 1'b1;
        repeat (n) @(negedge clk);
        cnt_evt[idx] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v; logic o;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12: reset state without any initialize pulse
        check("R12 irq_dl_n", {7'd0, irq_dl_n}, 8'h01);
        check("R12 irq_cm_n", {7'd0, irq_cm_n}, 8'h01);
        check("R12 ad_oe", {7'd0, ad_oe}, 8'h00);
        rd(8'h04, "R12 status", 8'h00);
        rd(8'h05, "R12 mask", 8'h00);

        // Table walk: R1 R2 R3 R7
        for (int i = 0; i < NV; i++) begin
            set_mode(VEC[i][25]);
            access(VEC[i][24], 1'b1, VEC[i][23:16], VEC[i][15:8], v, o);
            if (VEC[i][24]) check(VEC[i][25] ? "R3 write no drive" : "R2 write no drive", {7'd0, o}, 8'h00);
            else begin
                check("R6 read drive", {7'd0, o}, 8'h01);
                check(VEC[i][25] ? "R3/R1/R7 read" : "R2/R1/R7 read", v, VEC[i][7:0]);
            end
        end
        set_mode(1'b0);
        check("R6 idle no drive", {7'd0, ad_oe}, 8'h00);

        // R8: counting and saturation; R9 saturation status
        pulse_cnt(1, 3);
        rd(8'h01, "R8 count", 8'h03);
        pulse_cnt(2, 260);
        rd(8'h02, "R8 saturate", 8'hFF);
        rd(8'h04, "R9 sat status", 8'h10);
        check("R10 irq_cm_n low", {7'd0, irq_cm_n}, 8'h00);
        check("R10 irq_dl_n high", {7'd0, irq_dl_n}, 8'h01);
        wr(8'h05, 8'h10);
        check("R10 masked", {7'd0, irq_cm_n}, 8'h01);
        wr(8'h05, 8'h00);
        wr(8'h04, 8'h00);
        rd(8'h04, "R9 write zero keeps", 8'h10);
        wr(8'h04, 8'h10);
        rd(8'h04, "R9 write one clears", 8'h00);
        pulse_cnt(2, 5);
        rd(8'h04, "R9 no re-set when full", 8'h00);
        check("R10 irq_cm_n released", {7'd0, irq_cm_n}, 8'h01);

        // R9/R10: data-link and maintenance events
        @(negedge clk); dl_evt = 2'b01; @(negedge clk); dl_evt = 2'b00;
        repeat (2) @(negedge clk);
        check("R10 irq_dl_n low", {7'd0, irq_dl_n}, 8'h00);
        @(negedge clk); mt_evt = 2'b10; @(negedge clk); mt_evt = 2'b00;
        rd(8'h04, "R9 dl+mt status", 8'h81);
        wr(8'h04, 8'h80);
        rd(8'h04, "R9 partial clear", 8'h01);

        // R11: initialize across a full write
        @(negedge clk); init_n = 1'b0;
        repeat (4) @(negedge clk);
        access(1'b1, 1'b1, 8'h05, 8'h77, v, o);
        access(1'b0, 1'b1, 8'h05, 8'h00, v, o);
        check("R11 no drive in init", {7'd0, o}, 8'h00);
        init_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(8'h01, "R11 ctr1 cleared", 8'h00);
        rd(8'h02, "R11 ctr2 cleared", 8'h00);
        rd(8'h05, "R11 mask write lost", 8'h00);
        rd(8'h04, "R11 status kept", 8'h01);
        set_mode(1'b1);
        wr(8'h04, 8'hFF);
        rd(8'h04, "R3 clear via enable clock", 8'h00);
        set_mode(1'b0);

        // R4: chip select low
        access(1'b1, 1'b0, 8'h05, 8'h5A, v, o);
        access(1'b0, 1'b0, 8'h05, 8'h00, v, o);
        check("R4 no drive", {7'd0, o}, 8'h00);
        rd(8'h05, "R4 mask unchanged", 8'h00);

        // R5: host interface strapped off
        host_off = 1'b1;
        access(1'b1, 1'b1, 8'h05, 8'hC3, v, o);
        access(1'b0, 1'b1, 8'h05, 8'h00, v, o);
        check("R5 no drive", {7'd0, o}, 8'h00);
        host_off = 1'b0;
        rd(8'h05, "R5 mask unchanged", 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule